// File: doc/BRIEF.md
# Uplink Word Sequencer for a Contactless Tag

This block generates the continuous answer stream of a passive tag while no command is being received. After reset it steps through a programmed range of 32-bit words, which it reads one at a time from an external register file. Each word is turned into a 45-bit frame that carries row and column even parity. A fixed listen-window waveform comes before every frame. The result is a Manchester-coded level on a modulator-enable output.

All timing is counted in carrier clocks. One bit lasts P clocks, where P is 64 or 32 and is chosen by a static rate input. A companion downlink detector uses the listen-active flag to find the slot in which a reader may interrupt the stream.

A stop pulse parks the sequencer at the next segment or bit boundary. A restart pulse begins the range again from the first address.

Top module: `ulseq_top`

## Requirements
- R1: While `rst_n` is low, `mod_en` and `listen_act` are low. After release, two listen windows are sent, followed by the frame of the word at `first_addr`.
- R2: A listen window consists of five segments lasting P/2, P/2, 2P, P and P clocks. Their modulator levels are on, off, on, off, on.
- R3: `listen_act` is high during the first segment of every listen window and low at all other times.
- R4: A frame has 45 bits. It starts with four groups, each made of 8 data bits (bit 0 of the word first) followed by the group's even parity bit. Next come 8 column parity bits, where column k is the even parity of word bits k, k+8, k+16 and k+24. The frame ends with a 0 stop bit.
- R5: Each bit is Manchester coded. A 1 drives `mod_en` high for the first P/2 clocks and low for the second P/2; a 0 drives low then high.
- R6: P is 32 when `half_rate` is 1 and 64 when it is 0. Every listen-window and bit duration follows P.
- R7: After the frame of an address that is at or above `last_addr`, the next word is `first_addr`, preceded by two listen windows. In every other case the address increments and one listen window is sent.
- R8: When `first_addr` equals `last_addr`, that word repeats, each time preceded by two listen windows. When `first_addr` is above `last_addr`, only `first_addr` is sent.
- R9: `rd_addr` never exceeds 33. The sequence wraps after address 33 whatever `last_addr` holds, and a `first_addr` above 33 is treated as 33.
- R10: If bit a of `rd_protect` is set and `login_ok` is low, the frame for address a is 45 zero bits. With `login_ok` high the real word is sent. Both are sampled when the frame begins.
- R11: A one-cycle `stop_req` lets the current segment or bit run to its end. After that, `mod_en` and `listen_act` stay low until `restart`. A stop arriving on the last clock of a segment halts the sequencer at that boundary.
- R12: `restart` gives one quiet cycle and then the R1 sequence from `first_addr`. It discards any pending stop, including one given in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-derived clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_rate | input | 1 | Static rate select: 1 gives 32 clocks per bit |
| first_addr | input | 6 | First address of the range |
| last_addr | input | 6 | Last address of the range |
| rd_protect | input | 34 | Per-address read-protect flags |
| login_ok | input | 1 | Login active; lifts read protection |
| stop_req | input | 1 | Pulse: halt at the next boundary |
| restart | input | 1 | Pulse: start again from first_addr |
| rd_addr | output | 6 | Register-file read address |
| rd_data | input | 32 | Register-file word at rd_addr |
| mod_en | output | 1 | Modulator drive |
| listen_act | output | 1 | High in the downlink sampling slot |

## Verification
Two pairs of events can fall on the same clock. A stop pulse can coincide with the last clock of a segment. The bench provokes this by raising `stop_req` on the final clock of the second listen segment, and it passes only if the following on-segment never appears. A restart can arrive in the same cycle as a stop. Here the bench expects the restart to win, so a complete double listen window and the first frame must follow without a halt. Wrap-around and repeat cases are judged clock by clock against a waveform that the bench builds from its own model of the address sequence.

// File: rtl/ulseq_pkg.sv
package ulseq_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_LSN  = 2'd1,
        ST_DATA = 2'd2,
        ST_IDLE = 2'd3
    } seq_st_e;

    localparam int LSN_SEGS = 5;
endpackage

// File: rtl/ulseq_lsn_shape.sv
module ulseq_lsn_shape #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] per,
    input  logic [2:0]       seg,
    output logic [CNT_W-1:0] seg_end,
    output logic             seg_mod,
    output logic             seg_listen
);
    logic [CNT_W:0] len;

    // segment lengths in bit periods: 1/2, 1/2, 2, 1, 1
    always_comb begin
        case (seg)
            3'd0, 3'd1: len = {1'b0, per >> 1};
            3'd2:       len = {per, 1'b0};
            default:    len = {1'b0, per};
        endcase
        seg_end    = CNT_W'(len - (CNT_W+1)'(1));
        seg_mod    = ~seg[0];
        seg_listen = (seg == 3'd0);
    end
endmodule

// File: rtl/ulseq_framer.sv
module ulseq_framer #(
    parameter int GRP_BITS = 8,
    parameter int N_GRP    = 4,
    parameter int GRP_W    = 3,
    parameter int POS_W    = 4
) (
    input  logic [GRP_BITS*N_GRP-1:0] word,
    input  logic [GRP_W-1:0]          grp,
    input  logic [POS_W-1:0]          pos,
    output logic                      bit_o
);
    logic [GRP_BITS-1:0] row_data [N_GRP];
    logic [N_GRP-1:0]    row_par;
    logic [GRP_BITS-1:0] col_par;

    for (genvar g = 0; g < N_GRP; g++) begin : g_row
        assign row_data[g] = word[g*GRP_BITS +: GRP_BITS];
        assign row_par[g]  = ^row_data[g];
    end

    for (genvar c = 0; c < GRP_BITS; c++) begin : g_col
        logic [N_GRP-1:0] col_bits;
        for (genvar g = 0; g < N_GRP; g++) begin : g_tap
            assign col_bits[g] = word[g*GRP_BITS + c];
        end
        assign col_par[c] = ^col_bits;
    end

    logic [GRP_BITS:0] line;

    // the group past the last data group carries column parity and the stop 0
    always_comb begin
        line = {1'b0, col_par};
        for (int g = 0; g < N_GRP; g++) begin
            if (grp == GRP_W'(g)) line = {row_par[g], row_data[g]};
        end
        bit_o = 1'b0;
        for (int p = 0; p <= GRP_BITS; p++) begin
            if (pos == POS_W'(p)) bit_o = line[p];
        end
    end
endmodule

// File: rtl/ulseq_addr_step.sv
module ulseq_addr_step #(
    parameter int ADDR_W  = 6,
    parameter int N_WORDS = 34
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] last,
    output logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              wrap
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(N_WORDS - 1);

    always_comb begin
        load_addr = (first > TOP) ? TOP : first;
        wrap      = (cur >= last) || (cur >= TOP);
        next_addr = wrap ? load_addr : cur + ADDR_W'(1);
    end
endmodule

// File: rtl/ulseq_top.sv
module ulseq_top
    import ulseq_pkg::*;
#(
    parameter int BIT_CLKS = 64,
    parameter int GRP_BITS = 8,
    parameter int N_GRP    = 4,
    parameter int ADDR_W   = 6,
    parameter int N_WORDS  = 34
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      half_rate,
    input  logic [ADDR_W-1:0]         first_addr,
    input  logic [ADDR_W-1:0]         last_addr,
    input  logic [N_WORDS-1:0]        rd_protect,
    input  logic                      login_ok,
    input  logic                      stop_req,
    input  logic                      restart,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic [GRP_BITS*N_GRP-1:0] rd_data,
    output logic                      mod_en,
    output logic                      listen_act
);
    localparam int WORD_W = GRP_BITS * N_GRP;
    localparam int CNT_W  = $clog2(2 * BIT_CLKS);
    localparam int GRP_W  = $clog2(N_GRP + 1);
    localparam int POS_W  = $clog2(GRP_BITS + 1);
    localparam logic [2:0] LAST_SEG = 3'(LSN_SEGS - 1);

    typedef struct packed {
        seq_st_e            st;
        logic [2:0]         seg;
        logic               dbl;
        logic               stop_pend;
        logic [CNT_W-1:0]   cnt;
        logic [GRP_W-1:0]   grp;
        logic [POS_W-1:0]   pos;
        logic [ADDR_W-1:0]  addr;
        logic [WORD_W-1:0]  word;
    } seq_t;

    seq_t q, d;

    logic [CNT_W-1:0]  per, half, bit_end, seg_end;
    logic              seg_mod, seg_listen, fbit, prot_hit, wrap, halt;
    logic [ADDR_W-1:0] load_addr, next_addr;
    logic              chk_idle, chk_stop_half;

    assign per     = half_rate ? CNT_W'(BIT_CLKS / 2) : CNT_W'(BIT_CLKS);
    assign half    = per >> 1;
    assign bit_end = per - CNT_W'(1);

    ulseq_lsn_shape #(.CNT_W(CNT_W)) u_shape (
        .per(per), .seg(q.seg), .seg_end(seg_end),
        .seg_mod(seg_mod), .seg_listen(seg_listen)
    );

    ulseq_framer #(.GRP_BITS(GRP_BITS), .N_GRP(N_GRP), .GRP_W(GRP_W), .POS_W(POS_W)) u_framer (
        .word(q.word), .grp(q.grp), .pos(q.pos), .bit_o(fbit)
    );

    ulseq_addr_step #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_step (
        .cur(q.addr), .first(first_addr), .last(last_addr),
        .load_addr(load_addr), .next_addr(next_addr), .wrap(wrap)
    );

    always_comb begin
        prot_hit = 1'b0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (q.addr == ADDR_W'(i)) prot_hit = rd_protect[i];
        end
    end

    always_comb begin
        d    = q;
        halt = q.stop_pend | stop_req;
        case (q.st)
            ST_LOAD: begin
                d.addr      = load_addr;
                d.st        = ST_LSN;
                d.seg       = 3'd0;
                d.cnt       = '0;
                d.dbl       = 1'b1;
                d.stop_pend = 1'b0;
            end
            ST_LSN: begin
                if (stop_req) d.stop_pend = 1'b1;
                if (q.cnt >= seg_end) begin
                    d.cnt = '0;
                    if (halt) begin
                        d.st        = ST_IDLE;
                        d.stop_pend = 1'b0;
                    end else if (q.seg != LAST_SEG) begin
                        d.seg = q.seg + 3'd1;
                    end else if (q.dbl) begin
                        d.dbl = 1'b0;
                        d.seg = 3'd0;
                    end else begin
                        d.st   = ST_DATA;
                        d.grp  = '0;
                        d.pos  = '0;
                        d.word = (prot_hit && !login_ok) ? '0 : rd_data;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (stop_req) d.stop_pend = 1'b1;
                if (q.cnt >= bit_end) begin
                    d.cnt = '0;
                    if (halt) begin
                        d.st        = ST_IDLE;
                        d.stop_pend = 1'b0;
                    end else if (q.pos != POS_W'(GRP_BITS)) begin
                        d.pos = q.pos + POS_W'(1);
                    end else if (q.grp != GRP_W'(N_GRP)) begin
                        d.pos = '0;
                        d.grp = q.grp + GRP_W'(1);
                    end else begin
                        d.addr = next_addr;
                        d.dbl  = wrap;
                        d.st   = ST_LSN;
                        d.seg  = 3'd0;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: ;
        endcase
        if (restart) begin
            d.st        = ST_LOAD;
            d.stop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            ST_LSN:  mod_en = seg_mod;
            ST_DATA: mod_en = (q.cnt < half) ? fbit : ~fbit;
            default: mod_en = 1'b0;
        endcase
        listen_act = (q.st == ST_LSN) && seg_listen;
    end

    assign rd_addr       = q.addr;
    assign chk_idle      = (q.st == ST_IDLE);
    assign chk_stop_half = (q.st == ST_DATA) && (q.grp == GRP_W'(N_GRP)) &&
                           (q.pos == POS_W'(GRP_BITS)) && (q.cnt < half);
endmodule

// File: rtl/ulseq_chk.sv
module ulseq_chk #(
    parameter int ADDR_W  = 6,
    parameter int N_WORDS = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mod_en,
    input logic              listen_act,
    input logic              restart,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              in_idle,
    input logic              stop_half
);
    AST_LISTEN_ON_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        listen_act |-> mod_en); // R3
    AST_LISTEN_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(listen_act) |-> !mod_en); // R2
    AST_STOP_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stop_half |-> !mod_en); // R4
    AST_ADDR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr <= ADDR_W'(N_WORDS - 1)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && !restart) |=> in_idle); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!mod_en && !listen_act)); // R11
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!mod_en && !listen_act)); // R12
endmodule

bind ulseq_top ulseq_chk #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .listen_act(listen_act),
    .restart(restart), .rd_addr(rd_addr), .in_idle(chk_idle),
    .stop_half(chk_stop_half)
);

// File: tb/sim_ulseq_top.sv
module sim_ulseq_top;
    localparam int ADDR_W  = 6;
    localparam int N_WORDS = 34;
    localparam logic [N_WORDS-1:0] PROT_MAP = 34'h2_0000_0050; // words 4, 6, 33

    // {half_rate, first, last, login, word count}
    localparam logic [17:0] VECS [6] = '{
        {1'b1, 6'd3,  6'd5,  1'b0, 4'd4},
        {1'b1, 6'd7,  6'd7,  1'b0, 4'd2},
        {1'b0, 6'd1,  6'd2,  1'b0, 4'd3},
        {1'b1, 6'd32, 6'd40, 1'b0, 4'd3},
        {1'b1, 6'd6,  6'd2,  1'b0, 4'd2},
        {1'b1, 6'd4,  6'd6,  1'b1, 4'd3}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n, half_rate, login_ok, stop_req, restart;
    logic [ADDR_W-1:0] first_addr, last_addr, rd_addr;
    logic [31:0]       rd_data;
    logic [N_WORDS-1:0] rd_protect;
    logic              mod_en, listen_act;

    function automatic logic [31:0] mem_word(input logic [5:0] a);
        return (32'h9E37_79B9 * (32'(a) + 32'd1)) ^ {4{2'b10, a}};
    endfunction

    assign rd_data = mem_word(rd_addr);

    ulseq_top u0 (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
        .first_addr(first_addr), .last_addr(last_addr),
        .rd_protect(rd_protect), .login_ok(login_ok),
        .stop_req(stop_req), .restart(restart), .rd_addr(rd_addr),
        .rd_data(rd_data), .mod_en(mod_en), .listen_act(listen_act)
    );

    int n_chk = 0;
    int n_bad = 0;
    int err_cnt;
    logic [1:0] fa, fe;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic seg_open();
        err_cnt = 0; fa = '0; fe = '0;
    endtask

    task automatic seg_close(input string tag, input string what);
        check(err_cnt == 0, tag, what, 32'(fa), 32'(fe));
    endtask

    task automatic step(input logic em, input logic el);
        @(negedge clk);
        if ({mod_en, listen_act} !== {em, el}) begin
            if (err_cnt == 0) begin
                fa = {mod_en, listen_act};
                fe = {em, el};
            end
            err_cnt++;
        end
    endtask

    function automatic logic lsn_lvl(input int j, input int p);
        if (j < p / 2)  return 1'b1;
        if (j < p)      return 1'b0;
        if (j < 3 * p)  return 1'b1;
        if (j < 4 * p)  return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_lsn(input int p);
        for (int j = 0; j < 5 * p; j++) step(lsn_lvl(j, p), j < p / 2);
    endtask

    task automatic run_word(input logic [31:0] w, input int p);
        logic [44:0] fr;
        int k = 0;
        for (int g = 0; g < 4; g++) begin
            for (int r = 0; r < 8; r++) begin fr[k] = w[8*g + r]; k++; end
            fr[k] = ^w[8*g +: 8]; k++;
        end
        for (int c = 0; c < 8; c++) begin
            fr[k] = w[c] ^ w[c+8] ^ w[c+16] ^ w[c+24]; k++;
        end
        fr[k] = 1'b0;
        for (int b = 0; b < 45; b++)
            for (int c = 0; c < p; c++) step((c < p / 2) ? fr[b] : ~fr[b], 1'b0);
    endtask

    task automatic do_restart(input bit with_stop);
        @(negedge clk);
        restart = 1'b1;
        stop_req = with_stop;
        @(negedge clk);
        restart = 1'b0;
        stop_req = 1'b0;
        check({mod_en, listen_act} == 2'b00, "R12", "quiet load cycle",
              32'({mod_en, listen_act}), 32'd0);
    endtask

    function automatic logic [31:0] exp_word(input int a, input bit lg);
        if (PROT_MAP[a] && !lg) return 32'd0;
        return mem_word(6'(a));
    endfunction

    initial begin
        rst_n = 1'b0; half_rate = 1'b1; login_ok = 1'b0; stop_req = 1'b0;
        restart = 1'b0; first_addr = 6'd2; last_addr = 6'd3; rd_protect = PROT_MAP;

        // reset state
        repeat (3) @(negedge clk);
        check({mod_en, listen_act} == 2'b00, "R1", "outputs in reset",
              32'({mod_en, listen_act}), 32'd0);
        rst_n = 1'b1;
        seg_open(); run_lsn(32); run_lsn(32);
        seg_close("R1", "R3 double window after reset");
        seg_open(); run_word(exp_word(2, 1'b0), 32);
        seg_close("R1", "first frame after reset");

        // table walk
        for (int i = 0; i < 6; i++) begin
            logic [17:0] v = VECS[i];
            int p, a, f, l, n;
            bit lg, dbl;
            string tg;
            case (i)
                0: tg = "R7";
                1: tg = "R8";
                2: tg = "R6";
                3: tg = "R9";
                4: tg = "R8";
                default: tg = "R10";
            endcase
            half_rate = v[17]; first_addr = v[16:11]; last_addr = v[10:5];
            login_ok = v[4];
            do_restart(1'b0);
            p = v[17] ? 32 : 64;
            f = (int'(v[16:11]) > 33) ? 33 : int'(v[16:11]);
            l = int'(v[10:5]);
            lg = v[4];
            n = int'(v[3:0]);
            a = f; dbl = 1'b1;
            for (int w = 0; w < n; w++) begin
                seg_open(); run_lsn(p); if (dbl) run_lsn(p);
                seg_close("R2", $sformatf("R3 %s window(s) before word %0d", tg, a));
                seg_open(); run_word(exp_word(a, lg), p);
                seg_close((PROT_MAP[a] && !lg) ? "R10" : tg,
                          $sformatf("R4 R5 frame of word %0d", a));
                if (a >= l || a == 33) begin a = f; dbl = 1'b1; end
                else begin a++; dbl = 1'b0; end
            end
        end

        // stop in the middle of the long segment
        half_rate = 1'b1; first_addr = 6'd8; last_addr = 6'd9; login_ok = 1'b0;
        do_restart(1'b0);
        seg_open();
        for (int j = 0; j <= 40; j++) step(lsn_lvl(j, 32), j < 16);
        stop_req = 1'b1;
        for (int j = 41; j <= 95; j++) begin step(lsn_lvl(j, 32), 1'b0); stop_req = 1'b0; end
        for (int j = 0; j < 100; j++) step(1'b0, 1'b0);
        seg_close("R11", "halt at end of running segment");

        // stop on the last clock of a segment
        do_restart(1'b0);
        seg_open();
        for (int j = 0; j <= 31; j++) step(lsn_lvl(j, 32), j < 16);
        stop_req = 1'b1;
        step(1'b0, 1'b0);
        stop_req = 1'b0;
        for (int j = 0; j < 40; j++) step(1'b0, 1'b0);
        seg_close("R11", "stop on boundary clock");

        // restart and stop together: restart wins
        do_restart(1'b1);
        seg_open(); run_lsn(32); run_lsn(32); run_word(exp_word(8, 1'b0), 32);
        seg_close("R12", "stream after restart with stop");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule